// File: doc/BRIEF.md
# Ramping Stereo Gain Stage with Mute

This block scales a stream of 24-bit two's-complement stereo samples by a programmable linear gain. It takes one left/right pair at each output word strobe. A control write loads an 11-bit target level and a +12 dB boost flag. The level that is actually applied to the samples never jumps. On each word strobe it moves one code toward the target, so gain changes are heard as smooth fades instead of clicks.

Silence can be forced in two ways. A direct mute input silences every word while it is held high. A one-cycle mute event pulse silences a fixed window of output words and then releases by itself. System logic raises the event when a clock, format or filter setting changes, so that the transient is hidden. Each product of sample and gain is formed at full precision, rounded toward negative infinity, and saturated back to 24 bits.

Top module: `audio_gain_ramp`

## Requirements
- R1: After reset the applied level reads 1024 (unity), both outputs are zero and the boost flag is clear.
- R2: At applied level 1024 without boost, each output word equals its input sample. At level 0 each output word is zero.
- R3: A loaded target above 1024 (up to 2047) is treated as 1024, so the applied level never exceeds 1024.
- R4: At each word strobe the applied level moves exactly one code toward the target. Without a strobe it holds.
- R5: A target loaded mid-ramp makes the level continue from its current value toward the newest target.
- R6: Without boost, output = floor(sample × level / 1024), using the level as it was before that strobe's step. The same level is used for left and right.
- R7: With boost, output = floor(sample × level / 256), saturated to 0x7FFFFF or 0x800000 when the result is out of range.
- R8: A word strobe that arrives while the direct mute input is high produces zero on both channels. Normal data returns at the first strobe after the input falls.
- R9: After a mute event pulse, the next 3072 output words are zero and the 3073rd carries normal data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_stb | input | 1 | One-cycle output word strobe |
| cfg_load | input | 1 | Loads cfg_level and cfg_boost |
| cfg_level | input | 11 | Target level code |
| cfg_boost | input | 1 | Multiplies the gain by four when set |
| mute_in | input | 1 | Direct mute |
| mute_event | input | 1 | One-cycle pulse that starts the timed mute |
| in_left | input | 24 | Left sample |
| in_right | input | 24 | Right sample |
| out_left | output | 24 | Scaled left word |
| out_right | output | 24 | Scaled right word |
| cur_level | output | 11 | Applied level |

## Verification
The bench targets these corner cases:
- A negative sample at a fractional gain. Truncating toward zero instead of flooring would be one code high.
- A boosted sample past full scale. A missing clamp would wrap the sign.
- An out-of-range target. Without the clamp the level would climb past 1024.
- A retarget in mid-ramp. A restart from the old target would make the level jump.
- The timed mute, counted word by word. An off-by-one counter would release at word 3072 or 3074.
- Gaps between strobes. The ramp must not advance without a strobe.

// File: rtl/audio_gain_ramp.sv
module audio_gain_ramp #(
  parameter int DW         = 24,
  parameter int LW         = 11,
  parameter int UNITY      = 1024,
  parameter int BOOST_SH   = 2,
  parameter int MUTE_WORDS = 3072
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_stb,
  input  logic          cfg_load,
  input  logic [LW-1:0] cfg_level,
  input  logic          cfg_boost,
  input  logic          mute_in,
  input  logic          mute_event,
  input  logic [DW-1:0] in_left,
  input  logic [DW-1:0] in_right,
  output logic [DW-1:0] out_left,
  output logic [DW-1:0] out_right,
  output logic [LW-1:0] cur_level
);
  localparam int FRAC = $clog2(UNITY);
  localparam int PW   = DW + LW + 1;
  localparam int CW   = $clog2(MUTE_WORDS + 1);
  localparam logic [LW-1:0] UNITY_L = LW'(UNITY);
  localparam logic signed [PW-1:0] MAXV = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic [LW-1:0] tgt, lvl;
  logic          boost;
  logic [CW-1:0] mcnt;
  logic          silent;

  assign cur_level = lvl;
  assign silent    = mute_in | mute_event | (mcnt != '0);

  function automatic logic [DW-1:0] scale(input logic [DW-1:0] s,
                                          input logic [LW-1:0] g,
                                          input logic          b);
    logic signed [PW-1:0] p;
    p = PW'($signed(s)) * $signed({{(PW-LW){1'b0}}, g});
    p = b ? (p >>> (FRAC - BOOST_SH)) : (p >>> FRAC);
    if (p > MAXV)      p = MAXV;
    else if (p < MINV) p = MINV;
    return p[DW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt   <= UNITY_L;
      lvl   <= UNITY_L;
      boost <= 1'b0;
    end else begin
      if (cfg_load) begin
        tgt   <= (cfg_level > UNITY_L) ? UNITY_L : cfg_level;
        boost <= cfg_boost;
      end
      if (word_stb) begin
        if (tgt > lvl)      lvl <= lvl + 1'b1;
        else if (tgt < lvl) lvl <= lvl - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      mcnt <= '0;
    else if (mute_event)
      mcnt <= word_stb ? CW'(MUTE_WORDS - 1) : CW'(MUTE_WORDS);
    else if (word_stb && mcnt != '0)
      mcnt <= mcnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_left  <= '0;
      out_right <= '0;
    end else if (word_stb) begin
      out_left  <= silent ? '0 : scale(in_left,  lvl, boost);
      out_right <= silent ? '0 : scale(in_right, lvl, boost);
    end
  end
endmodule

// File: rtl/audio_gain_ramp_chk.sv
module audio_gain_ramp_chk #(
  parameter int DW    = 24,
  parameter int LW    = 11,
  parameter int UNITY = 1024
) (
  input logic          clk,
  input logic          rst_n,
  input logic          word_stb,
  input logic          mute_in,
  input logic          mute_event,
  input logic [DW-1:0] out_left,
  input logic [DW-1:0] out_right,
  input logic [LW-1:0] cur_level
);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !word_stb |=> $stable(cur_level));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |=> (cur_level == $past(cur_level)) ||
                 (cur_level == $past(cur_level) + 1'b1) ||
                 (cur_level + 1'b1 == $past(cur_level)));

  p_ceiling_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cur_level <= LW'(UNITY));

  p_direct_mute_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && mute_in) |=> (out_left == '0 && out_right == '0));

  p_event_mute_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && mute_event) |=> (out_left == '0 && out_right == '0));

  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !word_stb |=> ($stable(out_left) && $stable(out_right)));
endmodule

bind audio_gain_ramp audio_gain_ramp_chk #(.DW(DW), .LW(LW), .UNITY(UNITY)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .mute_in(mute_in),
  .mute_event(mute_event), .out_left(out_left), .out_right(out_right),
  .cur_level(cur_level));

// File: tb/test_audio_gain_ramp.sv
module test_audio_gain_ramp;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic word_stb = 1'b0, cfg_load = 1'b0, cfg_boost = 1'b0;
  logic mute_in = 1'b0, mute_event = 1'b0;
  logic [10:0] cfg_level = '0;
  logic [23:0] in_left = '0, in_right = '0;
  logic [23:0] out_left, out_right;
  logic [10:0] cur_level;

  int checks = 0, failures = 0;
  int m_lvl = 1024, m_tgt = 1024, m_cnt = 0;
  bit m_boost = 0;

  always #2 clk = ~clk;

  audio_gain_ramp i_audio_gain_ramp (
    .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .cfg_load(cfg_load),
    .cfg_level(cfg_level), .cfg_boost(cfg_boost), .mute_in(mute_in),
    .mute_event(mute_event), .in_left(in_left), .in_right(in_right),
    .out_left(out_left), .out_right(out_right), .cur_level(cur_level));

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] gain(input logic [23:0] s, input int g, input bit b);
    longint p;
    p = longint'($signed(s)) * g;
    p = p >>> (b ? 8 : 10);
    if (p > 64'sh7FFFFF) p = 64'sh7FFFFF;
    if (p < -64'sh800000) p = -64'sh800000;
    return p[23:0];
  endfunction

  task automatic load(input int code, input bit b);
    @(negedge clk);
    cfg_level = 11'(code); cfg_boost = b; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    m_tgt = (code > 1024) ? 1024 : code;
    m_boost = b;
  endtask

  task automatic word(input logic [23:0] l, input logic [23:0] r, input string tag);
    logic [23:0] el, er;
    bit quiet;
    quiet = mute_in || (m_cnt != 0);
    el = quiet ? 24'd0 : gain(l, m_lvl, m_boost);
    er = quiet ? 24'd0 : gain(r, m_lvl, m_boost);
    if (m_lvl < m_tgt) m_lvl++;
    else if (m_lvl > m_tgt) m_lvl--;
    if (m_cnt != 0) m_cnt--;
    @(negedge clk);
    in_left = l; in_right = r; word_stb = 1'b1;
    @(negedge clk);
    word_stb = 1'b0;
    check({tag, " left"}, out_left, el);
    check({tag, " right"}, out_right, er);
    check({tag, " level"}, cur_level, m_lvl);
  endtask

  task automatic t_reset;
    check("R1 level", cur_level, 1024);
    check("R1 left", out_left, 0);
    check("R1 right", out_right, 0);
    word(24'h123456, 24'hABCDEF, "R2 unity");
    word(24'h7FFFFF, 24'h800000, "R2 unity extremes");
  endtask

  task automatic t_ramp_down;
    load(1000, 0);
    for (int i = 0; i < 10; i++) word(24'hFFFFFD, 24'h400001, "R6 ramp");
    repeat (20) @(negedge clk);
    check("R4 hold without strobe", cur_level, m_lvl);
  endtask

  task automatic t_retarget;
    load(900, 0);
    for (int i = 0; i < 5; i++) word(24'h000400, 24'hFFFC00, "R5 toward 900");
    load(11'h7FF, 0);
    for (int i = 0; i < 140; i++) word(24'h0ABCDE, 24'hF54321, "R5 R3 retarget up");
    check("R3 clamped level", cur_level, 1024);
  endtask

  task automatic t_to_zero;
    load(0, 0);
    for (int i = 0; i < 1030; i++) word(24'h3FFFFF, 24'hC00001, "R4 ramp to zero");
    word(24'h7FFFFF, 24'h800000, "R2 level zero");
  endtask

  task automatic t_boost;
    load(1024, 1);
    for (int i = 0; i < 1024; i++) word(24'h001000, 24'hFFF000, "R7 ramp boosted");
    word(24'h100000, 24'hF00000, "R7 in range");
    word(24'h300000, 24'hD00000, "R7 saturate");
    word(24'h7FFFFF, 24'h800000, "R7 saturate extremes");
    load(1024, 0);
  endtask

  task automatic t_direct_mute;
    @(negedge clk); mute_in = 1'b1;
    word(24'h222222, 24'h333333, "R8 muted");
    word(24'h444444, 24'h555555, "R8 muted");
    @(negedge clk); mute_in = 1'b0;
    word(24'h666666, 24'h777777, "R8 released");
  endtask

  task automatic t_event_mute;
    @(negedge clk); mute_event = 1'b1;
    @(negedge clk); mute_event = 1'b0;
    m_cnt = 3072;
    for (int i = 0; i < 3072; i++) word(24'h0F0F0F, 24'hF0F0F0, "R9 window");
    word(24'h0F0F0F, 24'hF0F0F0, "R9 word 3073");
    check("R9 word 3073 nonzero", out_left != 0, 1);
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_ramp_down;
    t_retarget;
    t_to_zero;
    t_boost;
    t_direct_mute;
    t_event_mute;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule